// File: doc/BRIEF.md
# Configuration Command Port

This block is a small register-mapped command port for a platform controller. It holds three registers: a free data word, a control word and a two-bit status field. Software writes a command word into the control register. The block clears the reserved bits of that word and stores the result. In the same write it records completion in the status register, and it flags an error in the status register when the command is not recognised. Two command words are recognised: one requests a system shutdown and the other requests a system reset. Each one raises a request output for exactly one clock cycle.

The port exists on one platform variant only. A `variant_id` input selects whether it is present. On any other variant, an access to one of its three offsets writes nothing, reads zero and raises `bus_bad` in the cycle of the access. Offsets outside the three do not belong to this block. The block ignores them and never flags them.

A command sequencer with three states produces the request pulses. `ST_IDLE` is the resting state. `ST_SHUTDOWN` drives `shutdown_req` and `ST_RESET` drives `reset_req`. Transition `T_ISSUE_SHUT` enters `ST_SHUTDOWN` on a control write whose masked word is the shutdown command. Transition `T_ISSUE_RST` enters `ST_RESET` on a control write whose masked word is the reset command. Transition `T_RETIRE` returns to `ST_IDLE` on any cycle without a recognised command. A recognised command that arrives while a request state is active moves the sequencer straight to the state of the new command.

Top module: `cfgcmd_port`

## Requirements
- R1: The three registers respond only while `variant_id` equals 0x190. On any other value, a read or write at 0x0A0, 0x0A4 or 0x0A8 raises `bus_bad` in the same cycle, reads as zero and changes no register.
- R2: Offset 0x0A0 is a 32-bit data register. A write stores the full word, and a later read returns it unchanged.
- R3: A write to offset 0x0A4 stores the write data with bits 19 and 18 forced to zero. A read of 0x0A4 returns the stored word.
- R4: Every accepted write to 0x0A4 sets status bit 0 (complete). The status field is read at 0x0A8 as a 32-bit word zero-extended from two bits.
- R5: When the masked control word equals 0xC0800000, `shutdown_req` is high for exactly the one cycle after the write. The status becomes 1. This includes words that differ from 0xC0800000 only in bits 19:18.
- R6: When the masked control word equals 0xC0900000, `reset_req` is high for exactly the one cycle after the write, and the status becomes 1.
- R7: Any other control word leaves both request outputs low and sets the status to 3 (complete plus error, bit 1).
- R8: A write to offset 0x0A8 sets the status to bits 1:0 of the write data and discards the upper bits.
- R9: While `rst_n` is low and after its release, the data, control and status registers read zero and both request outputs are low.
- R10: Accesses to offsets other than 0x0A0, 0x0A4 and 0x0A8 never raise `bus_bad`, read as zero and change no register.
- R11: `shutdown_req` and `reset_req` are never high together. Two recognised commands in consecutive cycles produce one pulse each, in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_id | input | 12 | Platform variant code; the port is present at 0x190 |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| bus_bad | output | 1 | Access to a port offset on a variant without the port |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The hardest situation to reach is a recognised command that lands while the sequencer is still in a request state. That takes control writes in two consecutive cycles, which the normal one-write-per-task stimulus never produces. A directed test keeps the write strobe high across two clock edges and changes the data between them. It then checks one pulse per cycle and a return to idle. A second hard case is the reserved-bit alias: a word with bits 19:18 set must still fire the shutdown request. The vector table includes such a word and reads the masked value back.

// File: rtl/cfgcmd_pkg.sv
package cfgcmd_pkg;

    localparam int STAT_W = 2;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_DATA = 2'd1,
        REG_CTRL = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CMD_SHUTDOWN = 2'd0,
        CMD_RESET    = 2'd1,
        CMD_OTHER    = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SHUTDOWN = 2'd1,
        ST_RESET    = 2'd2
    } seq_state_e;

    localparam logic [STAT_W-1:0] STAT_DONE  = 2'b01;
    localparam logic [STAT_W-1:0] STAT_ERROR = 2'b11;

endpackage

// File: rtl/cfgcmd_decode.sv
module cfgcmd_decode
    import cfgcmd_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter int                VARIANT_W    = 12,
    parameter logic [VARIANT_W-1:0] VARIANT_CODE = 12'h190,
    parameter logic [ADDR_W-1:0] OFF_DATA     = 12'h0A0,
    parameter logic [ADDR_W-1:0] OFF_CTRL     = 12'h0A4,
    parameter logic [ADDR_W-1:0] OFF_STAT     = 12'h0A8
) (
    input  logic [VARIANT_W-1:0] variant_id,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    output reg_sel_e             sel,
    output logic                 bad
);

    localparam int NREG = 3;
    localparam logic [ADDR_W-1:0] OFFS [NREG] = '{OFF_DATA, OFF_CTRL, OFF_STAT};

    logic [NREG-1:0] hit;
    logic            present;
    logic            access;

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign hit[g] = (bus_addr == OFFS[g]);
    end

    assign present = (variant_id == VARIANT_CODE);
    assign access  = bus_wr | bus_rd;
    assign bad     = access & (|hit) & ~present;

    always_comb begin
        sel = REG_NONE;
        if (present) begin
            if (hit[0])      sel = REG_DATA;
            else if (hit[1]) sel = REG_CTRL;
            else if (hit[2]) sel = REG_STAT;
        end
    end

endmodule

// File: rtl/cfgcmd_regs.sv
module cfgcmd_regs
    import cfgcmd_pkg::*;
#(
    parameter int                DATA_W         = 32,
    parameter logic [DATA_W-1:0] CTRL_RSVD_MASK = 32'h000C_0000,
    parameter logic [DATA_W-1:0] CMD_SHUT_WORD  = 32'hC080_0000,
    parameter logic [DATA_W-1:0] CMD_RST_WORD   = 32'hC090_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [STAT_W-1:0] status_q,
    output logic              ctrl_we,
    output cmd_kind_e         cmd_kind
);

    localparam logic [DATA_W-1:0] CTRL_KEEP = ~CTRL_RSVD_MASK;

    logic [DATA_W-1:0] ctrl_masked;
    logic              data_we;
    logic              stat_we;

    assign ctrl_masked = bus_wdata & CTRL_KEEP;
    assign data_we     = bus_wr && (sel == REG_DATA);
    assign ctrl_we     = bus_wr && (sel == REG_CTRL);
    assign stat_we     = bus_wr && (sel == REG_STAT);

    always_comb begin
        if (ctrl_masked == CMD_SHUT_WORD)     cmd_kind = CMD_SHUTDOWN;
        else if (ctrl_masked == CMD_RST_WORD) cmd_kind = CMD_RESET;
        else                                  cmd_kind = CMD_OTHER;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            ctrl_q   <= '0;
            status_q <= '0;
        end else begin
            if (data_we) data_q <= bus_wdata;
            if (ctrl_we) begin
                ctrl_q   <= ctrl_masked;
                status_q <= (cmd_kind == CMD_OTHER) ? STAT_ERROR : STAT_DONE;
            end else if (stat_we) begin
                status_q <= bus_wdata[STAT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                REG_DATA: bus_rdata = data_q;
                REG_CTRL: bus_rdata = ctrl_q;
                REG_STAT: bus_rdata = {{(DATA_W-STAT_W){1'b0}}, status_q};
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cfgcmd_seq.sv
module cfgcmd_seq
    import cfgcmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_we,
    input  cmd_kind_e cmd_kind,
    output logic      shutdown_req,
    output logic      reset_req
);

    seq_state_e state_q, state_d;
    logic       issue_shut;
    logic       issue_rst;

    assign issue_shut = ctrl_we && (cmd_kind == CMD_SHUTDOWN);
    assign issue_rst  = ctrl_we && (cmd_kind == CMD_RESET);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions T_ISSUE_SHUT, T_ISSUE_RST, T_RETIRE
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_SHUTDOWN, ST_RESET: begin
                if (issue_shut)     state_d = ST_SHUTDOWN;
                else if (issue_rst) state_d = ST_RESET;
                else                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        shutdown_req = 1'b0;
        reset_req    = 1'b0;
        unique case (state_q)
            ST_SHUTDOWN: shutdown_req = 1'b1;
            ST_RESET:    reset_req    = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/cfgcmd_port.sv
module cfgcmd_port
    import cfgcmd_pkg::*;
#(
    parameter int                   ADDR_W         = 12,
    parameter int                   DATA_W         = 32,
    parameter int                   VARIANT_W      = 12,
    parameter logic [VARIANT_W-1:0] VARIANT_CODE   = 12'h190,
    parameter logic [ADDR_W-1:0]    OFF_DATA       = 12'h0A0,
    parameter logic [ADDR_W-1:0]    OFF_CTRL       = 12'h0A4,
    parameter logic [ADDR_W-1:0]    OFF_STAT       = 12'h0A8,
    parameter logic [DATA_W-1:0]    CTRL_RSVD_MASK = 32'h000C_0000,
    parameter logic [DATA_W-1:0]    CMD_SHUT_WORD  = 32'hC080_0000,
    parameter logic [DATA_W-1:0]    CMD_RST_WORD   = 32'hC090_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VARIANT_W-1:0] variant_id,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_bad,
    output logic                 shutdown_req,
    output logic                 reset_req
);

    reg_sel_e          sel;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [STAT_W-1:0] status_q;
    logic              ctrl_we;
    cmd_kind_e         cmd_kind;

    cfgcmd_decode #(
        .ADDR_W       (ADDR_W),
        .VARIANT_W    (VARIANT_W),
        .VARIANT_CODE (VARIANT_CODE),
        .OFF_DATA     (OFF_DATA),
        .OFF_CTRL     (OFF_CTRL),
        .OFF_STAT     (OFF_STAT)
    ) u_decode (
        .variant_id (variant_id),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .sel        (sel),
        .bad        (bus_bad)
    );

    cfgcmd_regs #(
        .DATA_W         (DATA_W),
        .CTRL_RSVD_MASK (CTRL_RSVD_MASK),
        .CMD_SHUT_WORD  (CMD_SHUT_WORD),
        .CMD_RST_WORD   (CMD_RST_WORD)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .data_q    (data_q),
        .ctrl_q    (ctrl_q),
        .status_q  (status_q),
        .ctrl_we   (ctrl_we),
        .cmd_kind  (cmd_kind)
    );

    cfgcmd_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (ctrl_we),
        .cmd_kind     (cmd_kind),
        .shutdown_req (shutdown_req),
        .reset_req    (reset_req)
    );

endmodule

// File: rtl/cfgcmd_port_chk.sv
module cfgcmd_port_chk #(
    parameter int                   ADDR_W       = 12,
    parameter int                   DATA_W       = 32,
    parameter int                   VARIANT_W    = 12,
    parameter int                   STAT_W       = 2,
    parameter logic [VARIANT_W-1:0] VARIANT_CODE = 12'h190,
    parameter logic [ADDR_W-1:0]    OFF_CTRL     = 12'h0A4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [VARIANT_W-1:0] variant_id,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_bad,
    input logic                 shutdown_req,
    input logic                 reset_req,
    input logic [DATA_W-1:0]    data_q,
    input logic [DATA_W-1:0]    ctrl_q,
    input logic [STAT_W-1:0]    status_q
);

    logic ctrl_wr_ok;
    assign ctrl_wr_ok = bus_wr && (bus_addr == OFF_CTRL) && (variant_id == VARIANT_CODE);

    // R1: a bad access is only ever flagged on another variant
    a_r1_bad_only_off_variant: assert property (@(posedge clk) disable iff (!rst_n)
        bus_bad |-> (variant_id != VARIANT_CODE));

    // R1: writes on another variant leave every register untouched
    a_r1_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && variant_id != VARIANT_CODE) |=>
            ($stable(data_q) && $stable(ctrl_q) && $stable(status_q)));

    // R4: an accepted control write always reports completion
    a_r4_status_done: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_ok |=> status_q[0]);

    // R5: a shutdown pulse follows an accepted control write
    a_r5_shut_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(ctrl_wr_ok));

    // R6: a reset pulse follows an accepted control write
    a_r6_rst_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(ctrl_wr_ok));

    // R11: never both requests together
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shutdown_req, reset_req}));

    // R11: a pulse not renewed by a write ends after one cycle
    a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ((shutdown_req || reset_req) && !ctrl_wr_ok) |=> !(shutdown_req || reset_req));

endmodule

bind cfgcmd_port cfgcmd_port_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .VARIANT_W    (VARIANT_W),
    .STAT_W       (cfgcmd_pkg::STAT_W),
    .VARIANT_CODE (VARIANT_CODE),
    .OFF_CTRL     (OFF_CTRL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .variant_id   (variant_id),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_bad      (bus_bad),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .data_q       (data_q),
    .ctrl_q       (ctrl_q),
    .status_q     (status_q)
);

// File: tb/cfgcmd_port_tb.sv
`timescale 1ns/1ps
module cfgcmd_port_tb;

    localparam logic [11:0] VAR_ON  = 12'h190;
    localparam logic [11:0] VAR_OFF = 12'h182;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] variant_id = VAR_ON;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_bad;
    logic        shutdown_req;
    logic        reset_req;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    cfgcmd_port u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .variant_id   (variant_id),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_bad      (bus_bad),
        .shutdown_req (shutdown_req),
        .reset_req    (reset_req)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        sh;
        logic        rs;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h0A0, 32'hDEADBEEF, 32'h0,        1'b0, 1'b0, 4'd2},  // R2
        '{1'b0, 12'h0A0, 32'h0,        32'hDEADBEEF, 1'b0, 1'b0, 4'd2},  // R2
        '{1'b1, 12'h0A4, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 12'h0A4, 32'h0,        32'hFFF3FFFF, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 12'h0A8, 32'h0,        32'h3,        1'b0, 1'b0, 4'd7},  // R7
        '{1'b1, 12'h0A4, 32'hC0800000, 32'h0,        1'b1, 1'b0, 4'd5},  // R5
        '{1'b0, 12'h0A8, 32'h0,        32'h1,        1'b0, 1'b0, 4'd5},  // R5
        '{1'b1, 12'h0A4, 32'hC08C0000, 32'h0,        1'b1, 1'b0, 4'd5},  // R5 alias
        '{1'b0, 12'h0A4, 32'h0,        32'hC0800000, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b1, 12'h0A4, 32'hC0900000, 32'h0,        1'b0, 1'b1, 4'd6},  // R6
        '{1'b0, 12'h0A8, 32'h0,        32'h1,        1'b0, 1'b0, 4'd6},  // R6
        '{1'b1, 12'h0A8, 32'hFFFFFFF6, 32'h0,        1'b0, 1'b0, 4'd8},  // R8
        '{1'b0, 12'h0A8, 32'h0,        32'h2,        1'b0, 1'b0, 4'd8},  // R8
        '{1'b1, 12'h0A4, 32'hC0A00000, 32'h0,        1'b0, 1'b0, 4'd7},  // R7
        '{1'b0, 12'h0A8, 32'h0,        32'h3,        1'b0, 1'b0, 4'd7},  // R7
        '{1'b1, 12'h0B0, 32'h12345678, 32'h0,        1'b0, 1'b0, 4'd10}, // R10
        '{1'b0, 12'h0B0, 32'h0,        32'h0,        1'b0, 1'b0, 4'd10}, // R10
        '{1'b0, 12'h0A0, 32'h0,        32'hDEADBEEF, 1'b0, 1'b0, 4'd10}  // R10
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, output logic bad);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1 bad = bus_bad;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        #1;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic bad);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata; bad = bus_bad;
        #1 bus_rd = 1'b0; bus_addr = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        bad;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 shutdown in reset", {31'b0, shutdown_req}, 32'h0);
        chk("R9 reset_req in reset", {31'b0, reset_req}, 32'h0);
        rst_n = 1'b1;
        do_read(12'h0A0, rd, bad); chk("R9 data after reset", rd, 32'h0);
        do_read(12'h0A4, rd, bad); chk("R9 ctrl after reset", rd, 32'h0);
        do_read(12'h0A8, rd, bad); chk("R9 status after reset", rd, 32'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            vec_t  v;
            string tag;
            v   = VECS[i];
            tag = $sformatf("R%0d vec%0d", v.req, i);
            if (v.wr) begin
                do_write(v.addr, v.data, bad);
                chk({tag, " bad"}, {31'b0, bad}, 32'h0);
                chk({tag, " shutdown"}, {31'b0, shutdown_req}, {31'b0, v.sh});
                chk({tag, " reset"}, {31'b0, reset_req}, {31'b0, v.rs});
                @(negedge clk); #1;
                chk({tag, " pulse ended"}, {30'b0, shutdown_req, reset_req}, 32'h0);
            end else begin
                do_read(v.addr, rd, bad);
                chk({tag, " rdata"}, rd, v.exp);
                chk({tag, " bad"}, {31'b0, bad}, 32'h0);
            end
        end

        // R1: other variant, offsets unmapped
        variant_id = VAR_OFF;
        do_write(12'h0A4, 32'hC0800000, bad);
        chk("R1 bad on write", {31'b0, bad}, 32'h1);
        chk("R1 no pulse", {30'b0, shutdown_req, reset_req}, 32'h0);
        do_write(12'h0A0, 32'h0BADF00D, bad);
        do_read(12'h0A8, rd, bad);
        chk("R1 read zero", rd, 32'h0);
        chk("R1 bad on read", {31'b0, bad}, 32'h1);
        do_read(12'h0B0, rd, bad);
        chk("R10 no bad outside window", {31'b0, bad}, 32'h0);
        variant_id = VAR_ON;
        do_read(12'h0A4, rd, bad); chk("R1 ctrl unchanged", rd, 32'hC0A00000);
        do_read(12'h0A8, rd, bad); chk("R1 status unchanged", rd, 32'h3);
        do_read(12'h0A0, rd, bad); chk("R1 data unchanged", rd, 32'hDEADBEEF);

        // R11: back-to-back commands
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h0A4; bus_wdata = 32'hC0800000;
        @(negedge clk);
        bus_wdata = 32'hC0900000;
        #1;
        chk("R11 first pulse shutdown", {30'b0, shutdown_req, reset_req}, 32'h2);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        #1;
        chk("R11 second pulse reset", {30'b0, shutdown_req, reset_req}, 32'h1);
        @(negedge clk); #1;
        chk("R11 back to idle", {30'b0, shutdown_req, reset_req}, 32'h0);

        // R9: reset mid-run clears state
        do_write(12'h0A0, 32'h55AA55AA, bad);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(12'h0A0, rd, bad); chk("R9 data cleared", rd, 32'h0);
        do_read(12'h0A4, rd, bad); chk("R9 ctrl cleared", rd, 32'h0);
        do_read(12'h0A8, rd, bad); chk("R9 status cleared", rd, 32'h0);

        summary();
        $finish;
    end

endmodule